// File: doc/BRIEF.md
# Register rename unit

This unit sits at the rename stage of an out-of-order core and handles a group of up to two instructions per cycle. It translates architectural register numbers into tags in one shared pool of physical registers. Each source operand comes back with its current physical tag and a flag that says whether that value has already been produced. Each instruction that writes a register gets a fresh physical tag from a free list. The unit also reports the tag that the destination held before, so the pipeline can release that tag when the instruction commits.

Within a group, a younger source can name the destination of the older slot. Comparators catch this case and steer the new tag to the younger source. A four-slot checkpoint store keeps copies of the map table and of the free-list read pointer. A branch can take one of these copies, and on a misprediction the unit restores both in one cycle. Commit returns old tags through a free port, and writeback marks tags ready through a second port.

Slot 0 is the older slot of a group. The upstream stage holds the group stable until `ren_ready_o` is high. Register 0 always maps to physical tag 0 and is never renamed.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i with ready set. Each source port returns the tag currently mapped to its register, together with that tag's ready bit.
- R2: A slot allocates when it is valid, writes a register, and its destination is not 0. It takes the next tag from one shared FIFO free list, slot 0 first. After reset the list holds tags 32 to 63 in ascending order. A slot that does not allocate reports destination tag 0. Register 0 always reads tag 0 with ready set.
- R3: When the free list holds fewer tags than the group needs, `ren_ready_o` is low. The group then takes no tags and changes no mapping.
- R4: When a slot 1 source equals the slot 0 destination and slot 0 allocates, the source gets slot 0's new tag with ready low, not the map table entry.
- R5: `old_tag_o` gives the tag mapped to the slot's destination before the group. If both slots name the same destination, slot 1 reports slot 0's new tag and the map keeps slot 1's tag.
- R6: A tag on the commit free port is appended to the tail of the free list and is handed out after the tags already free.
- R7: Allocation clears a tag's ready bit. A writeback sets it from the next cycle on, and a source lookup in the same cycle as the writeback already reports ready.
- R8: An accepted group with `ren_ckpt_i` high saves the map, including that group's own updates, and the post-allocation free-list pointer. It saves them into slot `ckpt_id_o`, and slots are used 0,1,2,3 in a ring. With all four slots live, a checkpoint request stalls the group. `br_ok_i` frees the oldest slot.
- R9: `br_bad_i` with `br_id_i` restores the map and the free-list pointer from that slot, so tags allocated after it are handed out again. It discards that slot and every younger one, so the next checkpoint reuses `br_id_i`. During that cycle `ren_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 2 | Slot valid, bit 0 is the older slot |
| ren_wr_i | input | 2 | Slot writes a destination register |
| ren_dst_i | input | 2x5 | Destination architectural register per slot |
| ren_srca_i | input | 2x5 | First source register per slot |
| ren_srcb_i | input | 2x5 | Second source register per slot |
| ren_ckpt_i | input | 1 | Take a checkpoint after this group |
| ren_ready_o | output | 1 | Group accepted this cycle |
| srca_tag_o | output | 2x6 | First source physical tag |
| srca_rdy_o | output | 2 | First source value ready |
| srcb_tag_o | output | 2x6 | Second source physical tag |
| srcb_rdy_o | output | 2 | Second source value ready |
| dst_tag_o | output | 2x6 | Newly allocated tag, 0 if none |
| old_tag_o | output | 2x6 | Previous tag of the destination |
| ckpt_id_o | output | 2 | Slot a checkpoint taken now would use |
| free_valid_i | input | 2 | Commit returns a tag |
| free_tag_i | input | 2x6 | Tag to return |
| wb_valid_i | input | 2 | Writeback valid |
| wb_tag_i | input | 2x6 | Tag written back |
| br_ok_i | input | 1 | Oldest checkpointed branch resolved correctly |
| br_bad_i | input | 1 | Misprediction, restore a checkpoint |
| br_id_i | input | 2 | Checkpoint slot to restore |

## Verification
A table of four back-to-back groups covers four cases. The first case is a slot 1 source that hits the slot 0 destination. The second is both slots writing the same register. The third is slot 0 writing register 0, where slot 1 must take the head tag and no bypass may fire. The fourth is a slot 1 source that names its own destination, which must read the old mapping. Together they separate bypass, old-tag and allocation-order errors. The directed part drains the free list to one tag and then to none. It shows that a group needing two tags takes nothing, and that a tag freed at commit comes out after the others. Checkpoint runs restore a map with later allocations, then fill all four slots and check that the ring wraps.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_ARCH_REGS  = 32;
  localparam int RN_PHYS_REGS  = 64;
  localparam int RN_CKPT_SLOTS = 4;

  function automatic logic [1:0] lane_cnt(input logic [1:0] v);
    return {1'b0, v[0]} + {1'b0, v[1]};
  endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_PHYS = 64,
  parameter int NUM_ARCH = 32,
  localparam int TW   = $clog2(NUM_PHYS),
  localparam int FL_N = NUM_PHYS - NUM_ARCH,
  localparam int IW   = $clog2(FL_N),
  localparam int PW   = IW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         pop_cnt_i,
  output logic [TW-1:0]      tag0_o,
  output logic [TW-1:0]      tag1_o,
  output logic [PW-1:0]      avail_o,
  output logic [PW-1:0]      head_next_o,
  input  logic [1:0]         push_i,
  input  logic [1:0][TW-1:0] push_tag_i,
  input  logic               restore_i,
  input  logic [PW-1:0]      restore_head_i
);
  logic [TW-1:0] mem_q [FL_N];
  logic [PW-1:0] head_q, tail_q, head_p1, tail_p1;

  assign head_p1     = head_q + PW'(1);
  assign tail_p1     = tail_q + PW'(push_i[0]);
  assign tag0_o      = mem_q[head_q[IW-1:0]];
  assign tag1_o      = mem_q[head_p1[IW-1:0]];
  assign avail_o     = tail_q - head_q;
  assign head_next_o = head_q + PW'(pop_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FL_N; i++) mem_q[i] <= TW'(NUM_ARCH + i);
      head_q <= '0;
      tail_q <= PW'(FL_N);
    end else begin
      if (push_i[0]) mem_q[tail_q[IW-1:0]]  <= push_tag_i[0];
      if (push_i[1]) mem_q[tail_p1[IW-1:0]] <= push_tag_i[1];
      tail_q <= tail_q + PW'(push_i[0]) + PW'(push_i[1]);
      head_q <= restore_i ? restore_head_i : head_next_o;
    end
  end

  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(pop_cnt_i) <= avail_o);
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(avail_o) - int'(pop_cnt_i) + int'(push_i[0]) + int'(push_i[1])) <= FL_N);
  p_free_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i[0] |-> push_tag_i[0] != '0);
endmodule

// File: rtl/rn_ready_array.sv
module rn_ready_array #(
  parameter int NUM_PHYS = 64,
  parameter int NUM_ARCH = 32,
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         clr_i,
  input  logic [1:0][TW-1:0] clr_tag_i,
  input  logic [1:0]         set_i,
  input  logic [1:0][TW-1:0] set_tag_i,
  input  logic [3:0][TW-1:0] rd_tag_i,
  output logic [3:0]         rd_rdy_o
);
  logic [NUM_PHYS-1:0] rdy_q;

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      rd_rdy_o[r] = rdy_q[rd_tag_i[r]]
                  | (set_i[0] && set_tag_i[0] == rd_tag_i[r])
                  | (set_i[1] && set_tag_i[1] == rd_tag_i[r]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) rdy_q[i] <= (i < NUM_ARCH);
    end else begin
      for (int k = 0; k < 2; k++) if (clr_i[k]) rdy_q[clr_tag_i[k]] <= 1'b0;
      for (int k = 0; k < 2; k++) if (set_i[k]) rdy_q[set_tag_i[k]] <= 1'b1;
    end
  end

  p_wb_visible_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[0] |=> rdy_q[$past(set_tag_i[0])]);
  p_zero_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q[0]);
  p_clr_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[1] |-> clr_tag_i[1] != '0);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   wr_i,
  input  logic [1:0][AW-1:0]           wr_arch_i,
  input  logic [1:0][TW-1:0]           wr_tag_i,
  input  logic                         load_i,
  input  logic [NUM_ARCH-1:0][TW-1:0]  load_map_i,
  input  logic [5:0][AW-1:0]           rd_arch_i,
  output logic [5:0][TW-1:0]           rd_tag_o,
  output logic [NUM_ARCH-1:0][TW-1:0]  next_map_o
);
  logic [NUM_ARCH-1:0][TW-1:0] map_q;

  for (genvar r = 0; r < 6; r++) begin : g_rd
    assign rd_tag_o[r] = map_q[rd_arch_i[r]];
  end

  // slot 1 is younger, so its write lands last
  always_comb begin
    next_map_o = map_q;
    if (wr_i[0]) next_map_o[wr_arch_i[0]] = wr_tag_i[0];
    if (wr_i[1]) next_map_o[wr_arch_i[1]] = wr_tag_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= TW'(i);
    end else begin
      map_q <= load_i ? load_map_i : next_map_o;
    end
  end

  p_zero_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_q[0] == '0);
  p_wr_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i[0] |-> wr_arch_i[0] != '0);
  p_load_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> wr_i == 2'b00);
endmodule

// File: rtl/rn_ckpt_stack.sv
module rn_ckpt_stack #(
  parameter int DEPTH    = 4,
  parameter int NUM_ARCH = 32,
  parameter int TW       = 6,
  parameter int PW       = 6,
  localparam int CW = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  logic [NUM_ARCH-1:0][TW-1:0] push_map_i,
  input  logic [PW-1:0]               push_head_i,
  input  logic                        release_i,
  input  logic                        restore_i,
  input  logic [CW-1:0]               restore_id_i,
  output logic                        full_o,
  output logic [CW-1:0]               id_o,
  output logic [NUM_ARCH-1:0][TW-1:0] rest_map_o,
  output logic [PW-1:0]               rest_head_o
);
  logic [NUM_ARCH-1:0][TW-1:0] snap_map_q [DEPTH];
  logic [PW-1:0]               snap_head_q [DEPTH];
  logic [CW-1:0]               oldest_q, tail_q, live_dist;
  logic [CW:0]                 cnt_q;

  assign full_o      = cnt_q == (CW+1)'(DEPTH);
  assign id_o        = tail_q;
  assign rest_map_o  = snap_map_q[restore_id_i];
  assign rest_head_o = snap_head_q[restore_id_i];
  assign live_dist   = restore_id_i - oldest_q;

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      snap_map_q[tail_q]  <= push_map_i;
      snap_head_q[tail_q] <= push_head_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oldest_q <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
    end else if (restore_i) begin
      tail_q <= restore_id_i;
      cnt_q  <= {1'b0, live_dist};
    end else begin
      tail_q   <= tail_q + CW'(push_i);
      oldest_q <= oldest_q + CW'(release_i);
      cnt_q    <= cnt_q + (CW+1)'(push_i) - (CW+1)'(release_i);
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (CW+1)'(DEPTH));
  p_no_push_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_release_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> cnt_q != '0);
  p_restore_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |-> {1'b0, live_dist} < cnt_q);
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int NUM_ARCH   = RN_ARCH_REGS,
  parameter int NUM_PHYS   = RN_PHYS_REGS,
  parameter int CKPT_DEPTH = RN_CKPT_SLOTS,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS),
  localparam int PW = $clog2(NUM_PHYS - NUM_ARCH) + 1,
  localparam int CW = $clog2(CKPT_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         ren_valid_i,
  input  logic [1:0]         ren_wr_i,
  input  logic [1:0][AW-1:0] ren_dst_i,
  input  logic [1:0][AW-1:0] ren_srca_i,
  input  logic [1:0][AW-1:0] ren_srcb_i,
  input  logic               ren_ckpt_i,
  output logic               ren_ready_o,
  output logic [1:0][TW-1:0] srca_tag_o,
  output logic [1:0]         srca_rdy_o,
  output logic [1:0][TW-1:0] srcb_tag_o,
  output logic [1:0]         srcb_rdy_o,
  output logic [1:0][TW-1:0] dst_tag_o,
  output logic [1:0][TW-1:0] old_tag_o,
  output logic [CW-1:0]      ckpt_id_o,
  input  logic [1:0]         free_valid_i,
  input  logic [1:0][TW-1:0] free_tag_i,
  input  logic [1:0]         wb_valid_i,
  input  logic [1:0][TW-1:0] wb_tag_i,
  input  logic               br_ok_i,
  input  logic               br_bad_i,
  input  logic [CW-1:0]      br_id_i
);
  logic [1:0]                  need, alloc;
  logic [1:0]                  pop_req, pop_eff;
  logic                        go, ck_full, ck_push;
  logic [TW-1:0]               fl_tag0, fl_tag1;
  logic [1:0][TW-1:0]          new_tag;
  logic [PW-1:0]               fl_avail, fl_head_next, ck_head;
  logic [5:0][AW-1:0]          mt_rd_arch;
  logic [5:0][TW-1:0]          mt_rd_tag;
  logic [NUM_ARCH-1:0][TW-1:0] mt_next, ck_map;
  logic [3:0]                  rdy_raw;
  logic                        byp_a1, byp_b1, same_dst;

  for (genvar s = 0; s < 2; s++) begin : g_need
    assign need[s] = ren_valid_i[s] & ren_wr_i[s] & (ren_dst_i[s] != '0);
  end

  assign pop_req = lane_cnt(need);
  assign go      = !br_bad_i && !(ren_ckpt_i && ck_full) && (PW'(pop_req) <= fl_avail);
  assign alloc   = need & {2{go}};
  assign pop_eff = lane_cnt(alloc);
  assign ck_push = ren_ckpt_i & go;

  assign new_tag[0] = fl_tag0;
  assign new_tag[1] = need[0] ? fl_tag1 : fl_tag0;

  assign mt_rd_arch = {ren_dst_i[1], ren_dst_i[0], ren_srcb_i[1], ren_srca_i[1],
                       ren_srcb_i[0], ren_srca_i[0]};

  // in-group dependence checks against the older slot
  assign byp_a1   = need[0] && (ren_srca_i[1] == ren_dst_i[0]);
  assign byp_b1   = need[0] && (ren_srcb_i[1] == ren_dst_i[0]);
  assign same_dst = need[0] && (ren_dst_i[1] == ren_dst_i[0]);

  assign srca_tag_o[0] = mt_rd_tag[0];
  assign srcb_tag_o[0] = mt_rd_tag[1];
  assign srca_tag_o[1] = byp_a1 ? new_tag[0] : mt_rd_tag[2];
  assign srcb_tag_o[1] = byp_b1 ? new_tag[0] : mt_rd_tag[3];
  assign srca_rdy_o[0] = rdy_raw[0];
  assign srcb_rdy_o[0] = rdy_raw[1];
  assign srca_rdy_o[1] = byp_a1 ? 1'b0 : rdy_raw[2];
  assign srcb_rdy_o[1] = byp_b1 ? 1'b0 : rdy_raw[3];

  assign dst_tag_o[0] = need[0] ? new_tag[0] : '0;
  assign dst_tag_o[1] = need[1] ? new_tag[1] : '0;
  assign old_tag_o[0] = mt_rd_tag[4];
  assign old_tag_o[1] = same_dst ? new_tag[0] : mt_rd_tag[5];
  assign ren_ready_o  = go;

  rn_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_free (
    .clk_i, .rst_ni,
    .pop_cnt_i      (pop_eff),
    .tag0_o         (fl_tag0),
    .tag1_o         (fl_tag1),
    .avail_o        (fl_avail),
    .head_next_o    (fl_head_next),
    .push_i         (free_valid_i),
    .push_tag_i     (free_tag_i),
    .restore_i      (br_bad_i),
    .restore_head_i (ck_head)
  );

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk_i, .rst_ni,
    .wr_i       (alloc),
    .wr_arch_i  (ren_dst_i),
    .wr_tag_i   (new_tag),
    .load_i     (br_bad_i),
    .load_map_i (ck_map),
    .rd_arch_i  (mt_rd_arch),
    .rd_tag_o   (mt_rd_tag),
    .next_map_o (mt_next)
  );

  rn_ready_array #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_rdy (
    .clk_i, .rst_ni,
    .clr_i     (alloc),
    .clr_tag_i (new_tag),
    .set_i     (wb_valid_i),
    .set_tag_i (wb_tag_i),
    .rd_tag_i  (mt_rd_tag[3:0]),
    .rd_rdy_o  (rdy_raw)
  );

  rn_ckpt_stack #(.DEPTH(CKPT_DEPTH), .NUM_ARCH(NUM_ARCH), .TW(TW), .PW(PW)) u_ckpt (
    .clk_i, .rst_ni,
    .push_i       (ck_push),
    .push_map_i   (mt_next),
    .push_head_i  (fl_head_next),
    .release_i    (br_ok_i),
    .restore_i    (br_bad_i),
    .restore_id_i (br_id_i),
    .full_o       (ck_full),
    .id_o         (ckpt_id_o),
    .rest_map_o   (ck_map),
    .rest_head_o  (ck_head)
  );

  p_fresh_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc == 2'b11) |-> dst_tag_o[0] != dst_tag_o[1]);
  p_stall_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ren_ready_o && free_valid_i == 2'b00 && !br_bad_i) |=> $stable(fl_avail));
endmodule

// File: tb/rename_unit_test.sv
module rename_unit_test;
  typedef struct packed {
    logic [4:0] d0, a0, b0, d1, a1, b1;
    logic [5:0] n0, n1, ta0, tb0, ta1, tb1, o0, o1;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{5'd1, 5'd2, 5'd3, 5'd4, 5'd1, 5'd5, 6'd32, 6'd33, 6'd2,  6'd3, 6'd32, 6'd5,  6'd1, 6'd4},
    '{5'd5, 5'd1, 5'd4, 5'd5, 5'd5, 5'd0, 6'd34, 6'd35, 6'd32, 6'd33, 6'd34, 6'd0, 6'd5, 6'd34},
    '{5'd0, 5'd5, 5'd6, 5'd7, 5'd0, 5'd5, 6'd0,  6'd36, 6'd35, 6'd6, 6'd0,  6'd35, 6'd0, 6'd7},
    '{5'd2, 5'd7, 5'd2, 5'd3, 5'd2, 5'd3, 6'd37, 6'd38, 6'd36, 6'd2, 6'd37, 6'd3,  6'd2, 6'd3}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      ren_valid_i, ren_wr_i;
  logic [1:0][4:0] ren_dst_i, ren_srca_i, ren_srcb_i;
  logic            ren_ckpt_i;
  logic            ren_ready_o;
  logic [1:0][5:0] srca_tag_o, srcb_tag_o, dst_tag_o, old_tag_o;
  logic [1:0]      srca_rdy_o, srcb_rdy_o;
  logic [1:0]      ckpt_id_o;
  logic [1:0]      free_valid_i, wb_valid_i;
  logic [1:0][5:0] free_tag_i, wb_tag_i;
  logic            br_ok_i, br_bad_i;
  logic [1:0]      br_id_i;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rename_unit uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid_i = '0; ren_wr_i = '0; ren_dst_i = '0; ren_srca_i = '0; ren_srcb_i = '0;
    ren_ckpt_i = 1'b0; free_valid_i = '0; free_tag_i = '0; wb_valid_i = '0; wb_tag_i = '0;
    br_ok_i = 1'b0; br_bad_i = 1'b0; br_id_i = '0;
  endtask

  task automatic grp(input logic [1:0] v, input int d0, a0, b0, d1, a1, b1, input logic ck);
    idle();
    ren_valid_i = v; ren_wr_i = v; ren_ckpt_i = ck;
    ren_dst_i[0] = 5'(d0); ren_srca_i[0] = 5'(a0); ren_srcb_i[0] = 5'(b0);
    ren_dst_i[1] = 5'(d1); ren_srca_i[1] = 5'(a1); ren_srcb_i[1] = 5'(b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1/R2: reset mapping
    @(negedge clk_i); grp(2'b00, 0, 9, 0, 0, 0, 0, 1'b0); #2;
    chk("R1 reset tag", srca_tag_o[0], 9);
    chk("R1 reset rdy", srca_rdy_o[0], 1);
    chk("R2 zero tag", srcb_tag_o[0], 0);
    chk("R2 zero rdy", srcb_rdy_o[0], 1);
    chk("R3 ready idle", ren_ready_o, 1);

    // vector table: R2 R4 R5
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      grp(2'b11, VECS[i].d0, VECS[i].a0, VECS[i].b0, VECS[i].d1, VECS[i].a1, VECS[i].b1, 1'b0);
      #2;
      chk("R3 accept", ren_ready_o, 1);
      chk("R2 dst0", dst_tag_o[0], VECS[i].n0);
      chk("R2 dst1", dst_tag_o[1], VECS[i].n1);
      chk("R1 srca0", srca_tag_o[0], VECS[i].ta0);
      chk("R1 srcb0", srcb_tag_o[0], VECS[i].tb0);
      chk("R4 srca1", srca_tag_o[1], VECS[i].ta1);
      chk("R4 srcb1", srcb_tag_o[1], VECS[i].tb1);
      chk("R5 old0", old_tag_o[0], VECS[i].o0);
      chk("R5 old1", old_tag_o[1], VECS[i].o1);
    end
    chk("R4 bypass not ready", srca_rdy_o[1], 0);

    // R7: cleared by alloc, set by writeback
    @(negedge clk_i); grp(2'b00, 0, 1, 0, 0, 0, 0, 1'b0); #2;
    chk("R7 alloc clears", srca_rdy_o[0], 0);
    wb_valid_i[0] = 1'b1; wb_tag_i[0] = 6'd32; #2;
    chk("R7 wb bypass", srca_rdy_o[0], 1);
    @(negedge clk_i); grp(2'b00, 0, 1, 0, 0, 0, 0, 1'b0); #2;
    chk("R7 wb held", srca_rdy_o[0], 1);

    // R2/R3: drain the list, 25 tags left (39..63)
    for (int g = 0; g < 12; g++) begin
      @(negedge clk_i); grp(2'b11, 10, 0, 0, 11, 0, 0, 1'b0); #2;
      chk("R2 fifo order", dst_tag_o[0], 39 + 2 * g);
    end
    @(negedge clk_i); grp(2'b11, 10, 0, 0, 11, 0, 0, 1'b0); #2;
    chk("R3 stall short", ren_ready_o, 0);
    @(negedge clk_i); grp(2'b10, 0, 0, 0, 9, 0, 0, 1'b0); #2;
    chk("R3 nothing taken", ren_ready_o, 1);
    chk("R3 last tag", dst_tag_o[1], 63);
    @(negedge clk_i); grp(2'b01, 12, 0, 0, 0, 0, 0, 1'b0);
    free_valid_i = 2'b01; free_tag_i[0] = 6'd1; #2;
    chk("R3 stall empty", ren_ready_o, 0);
    @(negedge clk_i); grp(2'b01, 12, 0, 0, 0, 0, 0, 1'b0); #2;
    chk("R6 freed reused", ren_ready_o, 1);
    chk("R6 freed tag", dst_tag_o[0], 1);
    @(negedge clk_i); idle(); free_valid_i = 2'b11; free_tag_i[0] = 6'd2; free_tag_i[1] = 6'd3;
    @(negedge clk_i); idle(); free_valid_i = 2'b11; free_tag_i[0] = 6'd6; free_tag_i[1] = 6'd8;

    // R8/R9: checkpoint and restore
    @(negedge clk_i); grp(2'b01, 20, 0, 0, 0, 0, 0, 1'b1); #2;
    chk("R8 ckpt id", ckpt_id_o, 0);
    chk("R6 free order", dst_tag_o[0], 2);
    @(negedge clk_i); grp(2'b11, 20, 0, 0, 21, 0, 0, 1'b0); #2;
    chk("R6 free order b", dst_tag_o[1], 6);
    @(negedge clk_i); grp(2'b00, 0, 0, 0, 0, 0, 0, 1'b1); #2;
    chk("R8 ckpt next id", ckpt_id_o, 1);
    @(negedge clk_i); grp(2'b01, 22, 0, 0, 0, 0, 0, 1'b0); br_bad_i = 1'b1; br_id_i = 2'd0; #2;
    chk("R9 stall on restore", ren_ready_o, 0);
    @(negedge clk_i); grp(2'b01, 22, 20, 21, 0, 0, 0, 1'b0); #2;
    chk("R9 map restored", srca_tag_o[0], 2);
    chk("R9 later undone", srcb_tag_o[0], 21);
    chk("R9 tag returned", dst_tag_o[0], 3);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i); grp(2'b00, 0, 0, 0, 0, 0, 0, 1'b1); #2;
      chk("R8 ring id", ckpt_id_o, c);
      chk("R8 ckpt accept", ren_ready_o, 1);
    end
    @(negedge clk_i); grp(2'b00, 0, 0, 0, 0, 0, 0, 1'b1); #2;
    chk("R8 full stall", ren_ready_o, 0);
    @(negedge clk_i); idle(); br_ok_i = 1'b1;
    @(negedge clk_i); grp(2'b00, 0, 0, 0, 0, 0, 0, 1'b1); #2;
    chk("R8 after release", ren_ready_o, 1);
    chk("R8 wrap id", ckpt_id_o, 0);

    @(negedge clk_i); idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule